// File: doc/BRIEF.md
# Edge-Selectable GPIO Port

This block is a port of sixteen general-purpose I/O lines behind a simple 16-bit register bus. Software chooses a direction for each line. It reads input levels through a gating mask and drives output levels from an output register. Each input line can raise a shared interrupt on a transition. Software picks whether that transition is rising or falling, line by line.

Input pins pass through a two-stage synchronizer. The synchronized value is then compared with the value held one clock earlier, and that comparison finds the edges. A detected edge of the selected polarity sets a sticky status bit, but only on an unmasked input line. The interrupt output is high while any status bit is set. Software clears status bits by writing ones to them. A pin that is an output drives the level held in the output register. A line that is switched to input keeps its last driven level on the pin-level port, so the level is already in place if the line is switched back. Register writes take effect on the clock edge that samples them. Reads are combinational from the current address.

Top module: `edgegpio_port`

## Requirements
- R1: After reset every line is an input (pin_oe all 0). The mask register reads 0xFFFF, the status register 0x0000, the output register 0x0000 and the gating register 0xFFFF. pin_out is 0 and irq_out is 0.
- R2: Byte offsets on bus_addr: 0x00 input level, 0x04 output register, 0x08 direction, 0x0C polarity, 0x10 mask, 0x14 status, 0x18 gating. The writable registers read back what was written. Any other offset reads 0 and ignores writes. A write to offset 0x00 changes nothing.
- R3: Direction bit 1 makes the line an input (pin_oe bit 0). Direction bit 0 makes it an output (pin_oe bit 1).
- R4: A read of offset 0x00 returns the pin level, synchronized through two clocks, ANDed bitwise with the gating register.
- R5: An output line drives its output-register bit on pin_out. A write to the output register changes pin_out only on output lines; input lines hold their last driven level. A line that becomes an output takes its output-register bit.
- R6: Polarity bit 1 selects a low-to-high transition and 0 selects a high-to-low transition. The status bit is set by the third rising clock edge after the pin changes.
- R7: A transition sets status only if the line is an input and its mask bit is 0. Masked lines and output lines never set status.
- R8: Writing the status register clears the bits written as 1 and leaves the bits written as 0. A new edge on a bit wins over a clear of that bit in the same cycle.
- R9: irq_out is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Level driven onto each pad |
| pin_oe | output | 16 | Pad output enable, 1 = driving |
| irq_out | output | 1 | Shared interrupt |

## Verification
The hardest case to reach is a clear write and a fresh edge landing on the same status bit in the same cycle. Equally hard is an edge that arrives while a line's direction or mask is changing. Both depend on the three-clock path from pin to status lining up exactly with a bus write. A long pseudo-random phase reaches them: it toggles pins and writes random registers on every clock, including status clears. A behavioural model checks every cycle through that phase. Directed runs before it pin down rising, falling, masked and output-line cases with values worked out by hand.

// File: rtl/edgegpio_pkg.sv
package edgegpio_pkg;
    localparam int OFF_LEVEL  = 'h00;
    localparam int OFF_OUT    = 'h04;
    localparam int OFF_DIR    = 'h08;
    localparam int OFF_POL    = 'h0C;
    localparam int OFF_MASK   = 'h10;
    localparam int OFF_STATUS = 'h14;
    localparam int OFF_GATE   = 'h18;
endpackage

// File: rtl/edgegpio_sync.sv
module edgegpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/edgegpio_regs.sv
module edgegpio_regs
    import edgegpio_pkg::*;
#(
    parameter int W      = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      outreg,
    output logic [W-1:0]      drive,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      gate
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] outreg;
        logic [W-1:0] drive;
        logic [W-1:0] pol;
        logic [W-1:0] mask;
        logic [W-1:0] gate;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                ADDR_W'(OFF_OUT):  cfg_d.outreg = wdata;
                ADDR_W'(OFF_DIR):  cfg_d.dir    = wdata;
                ADDR_W'(OFF_POL):  cfg_d.pol    = wdata;
                ADDR_W'(OFF_MASK): cfg_d.mask   = wdata;
                ADDR_W'(OFF_GATE): cfg_d.gate   = wdata;
                default: ;
            endcase
        end
        // Output lines follow the output register; input lines hold their level.
        cfg_d.drive = (cfg_q.drive & cfg_d.dir) | (cfg_d.outreg & ~cfg_d.dir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dir    <= '1;
            cfg_q.outreg <= '0;
            cfg_q.drive  <= '0;
            cfg_q.pol    <= '0;
            cfg_q.mask   <= '1;
            cfg_q.gate   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir    = cfg_q.dir;
    assign outreg = cfg_q.outreg;
    assign drive  = cfg_q.drive;
    assign pol    = cfg_q.pol;
    assign mask   = cfg_q.mask;
    assign gate   = cfg_q.gate;
endmodule

// File: rtl/edgegpio_irq.sv
module edgegpio_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] status;
    } det_t;

    det_t det_d, det_q;
    logic [W-1:0] rise, fall, hit, clr;

    always_comb begin
        det_d      = det_q;
        rise       = level & ~det_q.prev;
        fall       = ~level & det_q.prev;
        hit        = ((rise & pol) | (fall & ~pol)) & dir & ~mask;
        clr        = clr_en ? clr_bits : '0;
        det_d.prev = level;
        det_d.status = (det_q.status & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign status = det_q.status;
    assign irq    = |det_q.status;
endmodule

// File: rtl/edgegpio_port.sv
module edgegpio_port
    import edgegpio_pkg::*;
#(
    parameter int W           = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq_out
);
    logic [W-1:0] dir_w, outreg_w, drive_w, pol_w, mask_w, gate_w;
    logic [W-1:0] level_w, status_w;
    logic         clr_en;

    assign clr_en = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));

    edgegpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level_w)
    );

    edgegpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .dir    (dir_w),
        .outreg (outreg_w),
        .drive  (drive_w),
        .pol    (pol_w),
        .mask   (mask_w),
        .gate   (gate_w)
    );

    edgegpio_irq #(.W(W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_w),
        .dir      (dir_w),
        .pol      (pol_w),
        .mask     (mask_w),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata),
        .status   (status_w),
        .irq      (irq_out)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_LEVEL):  bus_rdata = level_w & gate_w;
            ADDR_W'(OFF_OUT):    bus_rdata = outreg_w;
            ADDR_W'(OFF_DIR):    bus_rdata = dir_w;
            ADDR_W'(OFF_POL):    bus_rdata = pol_w;
            ADDR_W'(OFF_MASK):   bus_rdata = mask_w;
            ADDR_W'(OFF_STATUS): bus_rdata = status_w;
            ADDR_W'(OFF_GATE):   bus_rdata = gate_w;
            default:             bus_rdata = '0;
        endcase
    end

    assign pin_out = drive_w;
    assign pin_oe  = ~dir_w;
endmodule

// File: rtl/edgegpio_port_chk.sv
module edgegpio_port_chk
    import edgegpio_pkg::*;
#(
    parameter int W      = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pin_out,
    input logic              irq_out,
    input logic [W-1:0]      dir_w,
    input logic [W-1:0]      mask_w,
    input logic [W-1:0]      status_w
);
    logic st_wr;
    assign st_wr = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));

    AST_INPUT_HOLDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ $past(pin_out)) & $past(dir_w) & dir_w) == '0); // R5

    AST_NEW_STATUS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & ~$past(status_w)) & ~($past(dir_w) & ~$past(mask_w))) == '0); // R7

    AST_STATUS_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_w) & ~status_w)) |-> $past(st_wr)); // R8

    AST_STATUS_FALL_ONES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_w) & ~status_w) & ~$past(bus_wdata)) == '0); // R8

    AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(st_wr)); // R9
endmodule

bind edgegpio_port edgegpio_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq_out   (irq_out),
    .dir_w     (dir_w),
    .mask_w    (mask_w),
    .status_w  (status_w)
);

// File: tb/edgegpio_port_tb_top.sv
`timescale 1ns/1ps
module edgegpio_port_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = 0;
    logic [15:0] pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    edgegpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [15:0] m_dir, m_out, m_drive, m_pol, m_mask, m_gate, m_status;
    logic [15:0] hist[$];

    function automatic logic [15:0] m_read(logic [4:0] a);
        case (a)
            5'h00: return hist[1] & m_gate;
            5'h04: return m_out;
            5'h08: return m_dir;
            5'h0C: return m_pol;
            5'h10: return m_mask;
            5'h14: return m_status;
            5'h18: return m_gate;
            default: return 16'h0;
        endcase
    endfunction

    function automatic string addr_tag(logic [4:0] a);
        if (a == 5'h00) return "R4";
        if (a == 5'h14) return "R8";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '1; m_out = '0; m_drive = '0; m_pol = '0;
            m_mask = '1; m_gate = '1; m_status = '0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            logic [15:0] lv, pv, hit, clr;
            lv  = hist[1];
            pv  = hist[2];
            hit = 0;
            for (int i = 0; i < 16; i++) begin
                if (m_dir[i] && !m_mask[i]) begin
                    if (m_pol[i] && lv[i] && !pv[i]) hit[i] = 1;
                    if (!m_pol[i] && !lv[i] && pv[i]) hit[i] = 1;
                end
            end
            clr = 0;
            if (bus_wr) begin
                case (bus_addr)
                    5'h04: begin
                        m_out = bus_wdata;
                        for (int i = 0; i < 16; i++) if (!m_dir[i]) m_drive[i] = bus_wdata[i];
                    end
                    5'h08: begin
                        m_dir = bus_wdata;
                        for (int i = 0; i < 16; i++) if (!m_dir[i]) m_drive[i] = m_out[i];
                    end
                    5'h0C: m_pol = bus_wdata;
                    5'h10: m_mask = bus_wdata;
                    5'h14: clr = bus_wdata;
                    5'h18: m_gate = bus_wdata;
                    default: ;
                endcase
            end
            m_status = (m_status & ~clr) | hit;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
        #1;
        if (rst_n && !done) begin
            chk("R3 pin_oe", pin_oe, ~m_dir);
            chk("R5 pin_out", pin_out, m_drive);
            chk("R9 irq_out", {15'h0, irq_out}, {15'h0, m_status != 0});
            chk({addr_tag(bus_addr), " bus_rdata"}, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(logic [4:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        bus_wr = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic set_pins(logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog expired");
        errors++;
        checks++;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(5'h08, 16'hFFFF, "R1 dir");
        rd_chk(5'h10, 16'hFFFF, "R1 mask");
        rd_chk(5'h14, 16'h0000, "R1 status");
        rd_chk(5'h04, 16'h0000, "R1 out");
        rd_chk(5'h18, 16'hFFFF, "R1 gate");
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 pin_out", pin_out, 16'h0);
        chk("R1 irq", {15'h0, irq_out}, 16'h0);

        // R6/R7 interrupts: low byte rising, high byte falling, line 15 masked
        wr(5'h0C, 16'h00FF);
        wr(5'h10, 16'h8000);
        set_pins(16'hFFFF);
        rd_chk(5'h14, 16'h00FF, "R6 rising");
        set_pins(16'h0000);
        rd_chk(5'h14, 16'h7FFF, "R7 masked line 15");
        chk("R9 irq set", {15'h0, irq_out}, 16'h1);
        wr(5'h14, 16'h000F);
        rd_chk(5'h14, 16'h7FF0, "R8 partial clear");
        wr(5'h08, 16'hFFFE);
        wr(5'h14, 16'hFFFF);
        rd_chk(5'h14, 16'h0000, "R8 full clear");
        chk("R9 irq clear", {15'h0, irq_out}, 16'h0);
        set_pins(16'h0001);
        set_pins(16'h0000);
        rd_chk(5'h14, 16'h0000, "R7 output line ignored");

        // R6 latency: status appears on the third edge
        wr(5'h08, 16'hFFFF);
        @(negedge clk); pin_in = 16'h0002;
        @(posedge clk); @(posedge clk); #1;
        chk("R6 not yet", {15'h0, irq_out}, 16'h0);
        @(posedge clk); #1;
        chk("R6 third edge", {15'h0, irq_out}, 16'h1);
        wr(5'h14, 16'hFFFF);
        set_pins(16'h0000);

        // R3/R5 outputs
        wr(5'h08, 16'hFF00);
        chk("R3 oe low byte", pin_oe, 16'h00FF);
        wr(5'h04, 16'hA5A5);
        chk("R5 low byte drives", pin_out, 16'h00A5);
        wr(5'h08, 16'h00FF);
        chk("R5 new outputs take register", pin_out, 16'hA5A5);
        wr(5'h04, 16'h0000);
        chk("R5 inputs hold", pin_out, 16'h00A5);
        wr(5'h00, 16'hFFFF);
        rd_chk(5'h04, 16'h0000, "R2 write to level ignored");
        chk("R2 pin_out after level write", pin_out, 16'h00A5);

        // R4 gated level read
        wr(5'h08, 16'hFFFF);
        wr(5'h18, 16'h0F0F);
        set_pins(16'h3CC3);
        rd_chk(5'h00, 16'h0C03, "R4 gated level");

        // R2 readback and unmapped offset
        wr(5'h0C, 16'h1234);
        rd_chk(5'h0C, 16'h1234, "R2 polarity");
        wr(5'h1C, 16'hFFFF);
        rd_chk(5'h1C, 16'h0000, "R2 unmapped");
        wr(5'h18, 16'hFFFF);

        // random phase: every cycle compared against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) pin_in = pin_in ^ (16'h1 << lfsr[7:4]);
            bus_wr    = lfsr[3:1] == 3'b101;
            bus_addr  = {lfsr[10:8], 2'b00};
            bus_wdata = {lfsr[7:0], lfsr[15:8]};
        end
        @(negedge clk);
        bus_wr = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule